// File: doc/BRIEF.md
# System Control Port Register Bank

This block is a small byte-wide register bank that sits on a synchronous port bus and serves as the control and status window of a board controller. The bus carries one address, one 8-bit write data path and one 8-bit read data path, each with its own single-cycle strobe. Writes update a few control levels that leave the block as plain outputs:

- a soft-reset request,
- a byte-order mode,
- a disk-activity lamp,
- an I/O address-map mode.

Writes to two further addresses produce one-clock toggle pulses for the write-lock logic of an external non-volatile memory.

Reads return one of three things. Some addresses give back the stored state. Some give fixed board identification and equipment bytes. Every other address reads as all ones, so that unpopulated locations look like a floating bus. Read data is registered and is valid one clock after the read strobe.

Top module: `sysctl_iobank`

## Requirements
- R1: A write to address 0x0092 sets the reset request output to data bit 0. The output follows that bit on every such write, one clock after the strobe.
- R2: A write to 0x0092 sets the byte-order flag from data bit 1, which drives the endian output. A read of 0x0092 returns the flag in bit 1 and zero in every other bit, so the reset request bit never reads back.
- R3: A write to 0x0808 sets the activity lamp output to data bit 0.
- R4: Lock toggle pulses:
  - Any write to 0x0810 raises lock pulse 1 for exactly one clock, starting one clock after the strobe.
  - Any write to 0x0812 does the same on lock pulse 2.
  - The two pulses are never high together.
- R5: A write to 0x081C keeps only data bits 3:0 as the control field. A read of 0x081C returns that field with bits 7:4 zero.
- R6: A write to 0x0850 stores data bit 0 as the map-mode flag and drives the map-mode output. A read of 0x0850 returns the flag in bit 0 with all other bits zero.
- R7: Reads of the fixed locations return these constants:

  | Address | Value |
  |---------|-------|
  | 0x0800  | 0xEF  |
  | 0x0802  | 0xAD  |
  | 0x0803  | 0xE0  |
  | 0x080C  | 0x3C  |
  | 0x0810  | 0x39  |
  | 0x0818  | 0x00  |
  | 0x0823  | 0x03  |

- R8: Writes to the read-only locations 0x0800, 0x0802 and 0x0803, and writes to any address not listed in R1 to R6, change no output and no readable state.
- R9: A read of any address not listed in R2, R5, R6 or R7 returns 0xFF. This covers 0x0808, 0x0812, 0x0814 and all other unlisted addresses.
- R10: While synchronous active-high reset is asserted, all of the following are zero:
  - all stored state,
  - every control output,
  - both lock pulses,
  - the read data.
- R11: Read data appears one clock after the read strobe and holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | 16 | Port address, shared by reads and writes |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| rd_data_o | output | 8 | Registered read data |
| rst_req_o | output | 1 | Soft-reset request level |
| endian_o | output | 1 | Byte-order mode level |
| map_mode_o | output | 1 | I/O address-map mode level |
| led_o | output | 1 | Disk-activity lamp level |
| lock1_o | output | 1 | Lock toggle pulse 1 |
| lock2_o | output | 1 | Lock toggle pulse 2 |

## Verification
The bench builds the block with its default parameters:
- a 16-bit address,
- an 8-bit data path,
- a 4-bit control field,
- identification constants equal to the values listed in R7.

With these defaults, a control-field write with ones in bits 7:4 exercises the masking. A reset-request write also shows that bit 0 is hidden on readback. All-ones reads are checked at unmapped addresses that sit directly next to mapped ones.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam logic [15:0] A_PORT92 = 16'h0092;
    localparam logic [15:0] A_CPUCFG = 16'h0800;
    localparam logic [15:0] A_FEAT   = 16'h0802;
    localparam logic [15:0] A_STAT   = 16'h0803;
    localparam logic [15:0] A_LAMP   = 16'h0808;
    localparam logic [15:0] A_EQUIP  = 16'h080C;
    localparam logic [15:0] A_LOCK1  = 16'h0810;
    localparam logic [15:0] A_LOCK2  = 16'h0812;
    localparam logic [15:0] A_KEY    = 16'h0818;
    localparam logic [15:0] A_CTRL   = 16'h081C;
    localparam logic [15:0] A_CACHE  = 16'h0823;
    localparam logic [15:0] A_MAP    = 16'h0850;

    typedef struct packed {
        logic port92;
        logic cpucfg;
        logic feat;
        logic stat;
        logic lamp;
        logic equip;
        logic lock1;
        logic lock2;
        logic key;
        logic ctrl;
        logic cache;
        logic map;
    } sel_t;

endpackage

// File: rtl/sysctl_dec.sv
module sysctl_dec
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    output sel_t              sel_o
);

    always_comb begin
        sel_o        = '0;
        sel_o.port92 = (addr_i == ADDR_W'(A_PORT92));
        sel_o.cpucfg = (addr_i == ADDR_W'(A_CPUCFG));
        sel_o.feat   = (addr_i == ADDR_W'(A_FEAT));
        sel_o.stat   = (addr_i == ADDR_W'(A_STAT));
        sel_o.lamp   = (addr_i == ADDR_W'(A_LAMP));
        sel_o.equip  = (addr_i == ADDR_W'(A_EQUIP));
        sel_o.lock1  = (addr_i == ADDR_W'(A_LOCK1));
        sel_o.lock2  = (addr_i == ADDR_W'(A_LOCK2));
        sel_o.key    = (addr_i == ADDR_W'(A_KEY));
        sel_o.ctrl   = (addr_i == ADDR_W'(A_CTRL));
        sel_o.cache  = (addr_i == ADDR_W'(A_CACHE));
        sel_o.map    = (addr_i == ADDR_W'(A_MAP));
    end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
    parameter int DATA_W = 8,
    parameter int CTRL_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              sel_port92_i,
    input  logic              sel_lamp_i,
    input  logic              sel_lock1_i,
    input  logic              sel_lock2_i,
    input  logic              sel_ctrl_i,
    input  logic              sel_map_i,
    output logic              rst_req_o,
    output logic              endian_o,
    output logic              lamp_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              map_o,
    output logic              lock1_o,
    output logic              lock2_o
);

    localparam int HI_W = DATA_W - CTRL_W;

    typedef struct packed {
        logic              rst_req;
        logic              endian;
        logic              lamp;
        logic [CTRL_W-1:0] ctrl;
        logic              map;
        logic              lock1;
        logic              lock2;
    } regs_t;

    regs_t st_d, st_q;

    // Bits above the control field only reach nothing: fold them away.
    logic unused_hi;
    assign unused_hi = ^wr_data_i[DATA_W-1:CTRL_W] ^ (HI_W < 0);

    always_comb begin
        st_d       = st_q;
        st_d.lock1 = 1'b0;
        st_d.lock2 = 1'b0;
        if (wr_en_i) begin
            if (sel_port92_i) begin
                st_d.rst_req = wr_data_i[0];
                st_d.endian  = wr_data_i[1];
            end
            if (sel_lamp_i) st_d.lamp  = wr_data_i[0];
            if (sel_ctrl_i) st_d.ctrl  = wr_data_i[CTRL_W-1:0];
            if (sel_map_i)  st_d.map   = wr_data_i[0];
            st_d.lock1 = sel_lock1_i;
            st_d.lock2 = sel_lock2_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign rst_req_o = st_q.rst_req;
    assign endian_o  = st_q.endian;
    assign lamp_o    = st_q.lamp;
    assign ctrl_o    = st_q.ctrl;
    assign map_o     = st_q.map;
    assign lock1_o   = st_q.lock1;
    assign lock2_o   = st_q.lock2;

    // R5: the control field changes only after a write aimed at it
    p_ctrl_only_by_write_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !(wr_en_i && sel_ctrl_i) |=> $stable(ctrl_o));

    // R4: a pulse never lasts beyond the cycle after its strobe
    p_lock1_single_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (lock1_o && !(wr_en_i && sel_lock1_i)) |=> !lock1_o);

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
    import sysctl_pkg::*;
#(
    parameter int              DATA_W  = 8,
    parameter int              CTRL_W  = 4,
    parameter logic [DATA_W-1:0] ID_CPU   = 8'hEF,
    parameter logic [DATA_W-1:0] ID_FEAT  = 8'hAD,
    parameter logic [DATA_W-1:0] ID_STAT  = 8'hE0,
    parameter logic [DATA_W-1:0] ID_EQUIP = 8'h3C,
    parameter logic [DATA_W-1:0] ID_EXT   = 8'h39,
    parameter logic [DATA_W-1:0] ID_KEY   = 8'h00,
    parameter logic [DATA_W-1:0] ID_CACHE = 8'h03
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rd_en_i,
    input  sel_t              sel_i,
    input  logic              endian_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              map_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam logic [DATA_W-1:0] FLOAT = {DATA_W{1'b1}};

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [DATA_W-1:0] mux_val;

    always_comb begin
        mux_val = FLOAT;
        if      (sel_i.port92) mux_val = DATA_W'({endian_i, 1'b0});
        else if (sel_i.cpucfg) mux_val = ID_CPU;
        else if (sel_i.feat)   mux_val = ID_FEAT;
        else if (sel_i.stat)   mux_val = ID_STAT;
        else if (sel_i.equip)  mux_val = ID_EQUIP;
        else if (sel_i.lock1)  mux_val = ID_EXT;
        else if (sel_i.key)    mux_val = ID_KEY;
        else if (sel_i.ctrl)   mux_val = DATA_W'(ctrl_i);
        else if (sel_i.cache)  mux_val = ID_CACHE;
        else if (sel_i.map)    mux_val = DATA_W'(map_i);
        else if (sel_i.lamp || sel_i.lock2) mux_val = FLOAT;
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en_i) rd_d.data = mux_val;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) rd_q <= '0;
        else       rd_q <= rd_d;
    end

    assign rd_data_o = rd_q.data;

    // R11: without a read strobe the returned byte holds
    p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_en_i |=> $stable(rd_data_o));

endmodule

// File: rtl/sysctl_iobank.sv
module sysctl_iobank
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CTRL_W = 4,
    parameter logic [DATA_W-1:0] ID_CPU   = 8'hEF,
    parameter logic [DATA_W-1:0] ID_FEAT  = 8'hAD,
    parameter logic [DATA_W-1:0] ID_STAT  = 8'hE0,
    parameter logic [DATA_W-1:0] ID_EQUIP = 8'h3C,
    parameter logic [DATA_W-1:0] ID_EXT   = 8'h39,
    parameter logic [DATA_W-1:0] ID_KEY   = 8'h00,
    parameter logic [DATA_W-1:0] ID_CACHE = 8'h03
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rst_req_o,
    output logic              endian_o,
    output logic              map_mode_o,
    output logic              led_o,
    output logic              lock1_o,
    output logic              lock2_o
);

    sel_t              sel;
    logic [CTRL_W-1:0] ctrl;

    sysctl_dec #(.ADDR_W(ADDR_W)) dec_i (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    sysctl_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) regs_i (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .wr_en_i      (wr_en_i),
        .wr_data_i    (wr_data_i),
        .sel_port92_i (sel.port92),
        .sel_lamp_i   (sel.lamp),
        .sel_lock1_i  (sel.lock1),
        .sel_lock2_i  (sel.lock2),
        .sel_ctrl_i   (sel.ctrl),
        .sel_map_i    (sel.map),
        .rst_req_o    (rst_req_o),
        .endian_o     (endian_o),
        .lamp_o       (led_o),
        .ctrl_o       (ctrl),
        .map_o        (map_mode_o),
        .lock1_o      (lock1_o),
        .lock2_o      (lock2_o)
    );

    sysctl_rdmux #(
        .DATA_W(DATA_W), .CTRL_W(CTRL_W),
        .ID_CPU(ID_CPU), .ID_FEAT(ID_FEAT), .ID_STAT(ID_STAT),
        .ID_EQUIP(ID_EQUIP), .ID_EXT(ID_EXT), .ID_KEY(ID_KEY),
        .ID_CACHE(ID_CACHE)
    ) rdmux_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .rd_en_i   (rd_en_i),
        .sel_i     (sel),
        .endian_i  (endian_o),
        .ctrl_i    (ctrl),
        .map_i     (map_mode_o),
        .rd_data_o (rd_data_o)
    );

    logic wr_any_state;
    assign wr_any_state = (addr_i == ADDR_W'(A_PORT92)) || (addr_i == ADDR_W'(A_LAMP))
                       || (addr_i == ADDR_W'(A_CTRL))   || (addr_i == ADDR_W'(A_MAP));

    // R1: reset request follows bit 0 of each write to its port
    p_rst_follow_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && addr_i == ADDR_W'(A_PORT92)) |=> (rst_req_o == $past(wr_data_i[0])));

    // R4: lock pulse 1 follows its write
    p_lock1_pulse_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && addr_i == ADDR_W'(A_LOCK1)) |=> lock1_o);

    // R4: the two pulses never overlap
    p_lock_excl_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({lock1_o, lock2_o}));

    // R8: writes elsewhere leave every level output alone
    p_levels_kept_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !(wr_en_i && wr_any_state) |=> $stable({rst_req_o, endian_o, map_mode_o, led_o}));

    // R9: the lock-2 and cache-flush ports float on read
    p_float_read_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_en_i && (addr_i == ADDR_W'(A_LOCK2) || addr_i == ADDR_W'(16'h0814)))
        |=> (rd_data_o == {DATA_W{1'b1}}));

    // R5: control-field readback has zero upper bits
    p_ctrl_upper_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_en_i && addr_i == ADDR_W'(A_CTRL)) |=> (rd_data_o[DATA_W-1:CTRL_W] == '0));

endmodule

// File: tb/sysctl_iobank_tb.sv
module sysctl_iobank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rst_req, endian, map_mode, led, lock1, lock2;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sysctl_iobank dut_i (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .rst_req_o(rst_req), .endian_o(endian), .map_mode_o(map_mode),
        .led_o(led), .lock1_o(lock1), .lock2_o(lock2)
    );

    // {op, addr, data}: op 0 = write data, op 1 = read and expect data
    localparam int NV = 30;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 16'h0800, 8'hEF}, {1'b1, 16'h0802, 8'hAD}, {1'b1, 16'h0803, 8'hE0},
        {1'b1, 16'h080C, 8'h3C}, {1'b1, 16'h0810, 8'h39}, {1'b1, 16'h0818, 8'h00},
        {1'b1, 16'h0823, 8'h03}, {1'b1, 16'h0814, 8'hFF}, {1'b1, 16'h0808, 8'hFF},
        {1'b1, 16'h0812, 8'hFF}, {1'b1, 16'h1234, 8'hFF}, {1'b1, 16'h0851, 8'hFF},
        {1'b1, 16'h0092, 8'h00}, {1'b1, 16'h081C, 8'h00}, {1'b1, 16'h0850, 8'h00},
        {1'b0, 16'h0092, 8'h03}, {1'b1, 16'h0092, 8'h02},
        {1'b0, 16'h081C, 8'hFA}, {1'b1, 16'h081C, 8'h0A},
        {1'b0, 16'h0850, 8'hFF}, {1'b1, 16'h0850, 8'h01},
        {1'b0, 16'h0800, 8'h55}, {1'b1, 16'h0800, 8'hEF},
        {1'b0, 16'h0814, 8'hAA}, {1'b1, 16'h081C, 8'h0A},
        {1'b1, 16'h0092, 8'h02},
        {1'b0, 16'h0092, 8'h01}, {1'b1, 16'h0092, 8'h00},
        {1'b0, 16'h081C, 8'h05}, {1'b1, 16'h081C, 8'h05}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    logic seen1, seen2;

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        seen1 = lock1; seen2 = lock2;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    logic [7:0] got;

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 outputs", {2'b0, rst_req, endian, map_mode, led, lock1, lock2}, 8'h00);
        chk("R10 rd_data", rd_data, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][24]) begin
                rd(VEC[i][23:8], got);
                chk($sformatf("R2/R5/R6/R7/R8/R9 vec %0d", i), got, VEC[i][7:0]);
            end else begin
                wr(VEC[i][23:8], VEC[i][7:0]);
            end
        end

        // R1: reset request follows bit 0
        wr(16'h0092, 8'h01); chk("R1 set", {7'b0, rst_req}, 8'h01);
        wr(16'h0092, 8'h02); chk("R1 clear", {7'b0, rst_req}, 8'h00);
        chk("R2 endian out", {7'b0, endian}, 8'h01);

        // R3: lamp
        wr(16'h0808, 8'h01); chk("R3 on", {7'b0, led}, 8'h01);
        wr(16'h0808, 8'hFE); chk("R3 off", {7'b0, led}, 8'h00);

        // R4: lock pulses
        wr(16'h0810, 8'h00);
        chk("R4 lock1 high", {6'b0, seen1, seen2}, 8'h02);
        @(negedge clk); chk("R4 lock1 one cycle", {6'b0, lock1, lock2}, 8'h00);
        wr(16'h0812, 8'h77);
        chk("R4 lock2 high", {6'b0, seen1, seen2}, 8'h01);
        @(negedge clk); chk("R4 lock2 one cycle", {6'b0, lock1, lock2}, 8'h00);

        // R6: map output
        wr(16'h0850, 8'h01); chk("R6 map on", {7'b0, map_mode}, 8'h01);
        wr(16'h0850, 8'h02); chk("R6 map off", {7'b0, map_mode}, 8'h00);

        // R8: writes to read-only and unmapped addresses touch no output
        wr(16'h0808, 8'h01); wr(16'h0850, 8'h01); wr(16'h0092, 8'h03);
        wr(16'h0803, 8'h00); wr(16'h0802, 8'h00); wr(16'h0809, 8'h00); wr(16'h0093, 8'h00);
        chk("R8 levels kept", {4'b0, rst_req, endian, map_mode, led}, 8'h0F);

        // R11: read data holds without strobe
        rd(16'h0800, got);
        addr = 16'h0802;
        repeat (3) @(negedge clk);
        chk("R11 hold", rd_data, 8'hEF);

        // R10: reset mid-run clears everything
        wr(16'h081C, 8'h0F);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R10 mid outputs", {2'b0, rst_req, endian, map_mode, led, lock1, lock2}, 8'h00);
        chk("R10 mid rd_data", rd_data, 8'h00);
        @(negedge clk); rst = 1'b0;
        rd(16'h081C, got); chk("R10 ctrl cleared", got, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule